// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block forms the 32-bit address of a memory operand from up to three terms: a base register, an index register multiplied by 1, 2, 4 or 8, and a signed displacement. A decoder upstream supplies a descriptor for each operand. The descriptor holds a flag and a register number for the base, a flag, a register number and a scale code for the index, and a displacement with its size code. Any subset of the three terms may be present. With no terms present the address is zero. With only a displacement the address is that displacement, which is direct addressing. With only a base the address is the register contents, which is indirect addressing.

The block reads an external eight-entry, 32-bit register file through two combinational read ports, one for the base and one for the index. The register numbers from the descriptor drive those ports directly. The sum wraps modulo 2^32 and is captured in a register. The address and its valid strobe therefore appear one clock after the descriptor is presented.

Top module: `eff_addr_gen`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), `ea_valid` is 0 and `ea_out` is 0.
- R2: `ea_valid` is 1 in the cycle after a clock edge that sampled `in_valid` high. It is 0 after an edge that sampled `in_valid` low.
- R3: When `use_base` is 1, the word on `rf_base_data` is added to the address. `rf_base_addr` always equals `base_sel`. When `use_base` is 0, the base register adds nothing.
- R4: When `use_index` is 1, the word on `rf_index_data` is shifted left by `scale_code` and added. Scale codes 0, 1, 2 and 3 give factors 1, 2, 4 and 8. Bits shifted out above bit 31 are discarded. `rf_index_addr` always equals `index_sel`.
- R5: When `use_index` is 0, neither the index register nor `scale_code` affects the address.
- R6: `disp_size` selects the displacement term:
  - 0 gives zero.
  - 1 gives `disp_bytes[7:0]` sign-extended.
  - 2 gives `disp_bytes[15:0]` sign-extended.
  - 3 gives all 32 bits.
  Bits of `disp_bytes` above the selected size are ignored.
- R7: The sum of the terms wraps modulo 2^32, and no overflow is reported.
- R8: In a cycle where `in_valid` is low, `ea_out` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Descriptor valid this cycle |
| use_base | input | 1 | Base term present |
| base_sel | input | 3 | Base register number |
| use_index | input | 1 | Index term present |
| index_sel | input | 3 | Index register number |
| scale_code | input | 2 | Index shift amount (factor 1/2/4/8) |
| disp_size | input | 2 | Displacement size: none, 8, 16, 32 bits |
| disp_bytes | input | 32 | Displacement bits |
| rf_base_addr | output | 3 | Register file read address for the base |
| rf_base_data | input | 32 | Register file read data for the base |
| rf_index_addr | output | 3 | Register file read address for the index |
| rf_index_data | input | 32 | Register file read data for the index |
| ea_out | output | 32 | Effective address |
| ea_valid | output | 1 | Effective address valid |

## Verification
The bench targets sign extension at the boundaries, 0xFF as an 8-bit displacement and 0x8000 as a 16-bit one. If the design zero-extended these, the address would land 256 or 65536 bytes too high. It also fills the unused upper displacement bytes with junk, which a design that did not mask them would add into the sum.

Other vectors use disabled terms with non-zero selectors and scale codes. A design that ignored the enable flags would return an address offset by the unused register. Sums that carry past bit 31, and an index shifted out of the word, expose any design that saturates or widens the result. Random descriptors are then checked against an independent model, and timing checks catch a valid strobe that is early, late, or leaves the output unheld.

// File: rtl/eff_addr_gen.sv
module eff_addr_gen #(
  parameter int AW = 32,
  parameter int RN = 8,
  localparam int SW = $clog2(RN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          use_base,
  input  logic [SW-1:0] base_sel,
  input  logic          use_index,
  input  logic [SW-1:0] index_sel,
  input  logic [1:0]    scale_code,
  input  logic [1:0]    disp_size,
  input  logic [AW-1:0] disp_bytes,
  output logic [SW-1:0] rf_base_addr,
  input  logic [AW-1:0] rf_base_data,
  output logic [SW-1:0] rf_index_addr,
  input  logic [AW-1:0] rf_index_data,
  output logic [AW-1:0] ea_out,
  output logic          ea_valid
);

  logic [AW-1:0] base_term, index_term, disp_term, sum;

  assign rf_base_addr  = base_sel;
  assign rf_index_addr = index_sel;

  assign base_term  = use_base  ? rf_base_data : '0;
  assign index_term = use_index ? (rf_index_data << scale_code) : '0;

  always_comb begin
    case (disp_size)
      2'd1:    disp_term = {{(AW-8){disp_bytes[7]}}, disp_bytes[7:0]};
      2'd2:    disp_term = {{(AW-16){disp_bytes[15]}}, disp_bytes[15:0]};
      2'd3:    disp_term = disp_bytes;
      default: disp_term = '0;
    endcase
  end

  assign sum = base_term + index_term + disp_term;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea_valid <= 1'b0;
      ea_out   <= '0;
    end else begin
      ea_valid <= in_valid;
      if (in_valid) ea_out <= sum;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (!ea_valid && ea_out == '0));

  // R2
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ea_valid);

  // R2
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !ea_valid);

  // R8
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(ea_out));

  // R6
  direct_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !use_base && !use_index && disp_size == 2'd3) |=> ea_out == $past(disp_bytes));

  // R6
  empty_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !use_base && !use_index && disp_size == 2'd0) |=> ea_out == '0);

endmodule

// File: tb/eff_addr_gen_tb_top.sv
module eff_addr_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, use_base = 1'b0, use_index = 1'b0;
  logic [2:0] base_sel = '0, index_sel = '0;
  logic [1:0] scale_code = '0, disp_size = '0;
  logic [31:0] disp_bytes = '0;
  logic [2:0] rf_base_addr, rf_index_addr;
  logic [31:0] rf_base_data, rf_index_data, ea_out;
  logic ea_valid;
  int total = 0, bad = 0;
  bit finished = 0;

  logic [31:0] regs [8];
  initial begin
    regs[0] = 32'h0000_1000; regs[1] = 32'h0000_0010;
    regs[2] = 32'hFFFF_FFF0; regs[3] = 32'h8000_0000;
    regs[4] = 32'h1234_5678; regs[5] = 32'h0000_0004;
    regs[6] = 32'h7FFF_FFFF; regs[7] = 32'hFFFF_FFFF;
  end
  assign rf_base_data  = regs[rf_base_addr];
  assign rf_index_data = regs[rf_index_addr];

  always #10 clk = ~clk;

  eff_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .use_base(use_base), .base_sel(base_sel),
    .use_index(use_index), .index_sel(index_sel),
    .scale_code(scale_code), .disp_size(disp_size), .disp_bytes(disp_bytes),
    .rf_base_addr(rf_base_addr), .rf_base_data(rf_base_data),
    .rf_index_addr(rf_index_addr), .rf_index_data(rf_index_data),
    .ea_out(ea_out), .ea_valid(ea_valid)
  );

  typedef struct packed {
    logic        ub;
    logic [2:0]  bs;
    logic        ui;
    logic [2:0]  is;
    logic [1:0]  sc;
    logic [1:0]  ds;
    logic [31:0] disp;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0,3'd0,1'b0,3'd0,2'd0,2'd3,32'hDEADBEEF,32'hDEADBEEF}, // R6 direct
    '{1'b0,3'd5,1'b0,3'd6,2'd2,2'd0,32'hFFFFFFFF,32'h00000000}, // R6 none, R3 R5 off
    '{1'b1,3'd4,1'b0,3'd0,2'd0,2'd0,32'h0,32'h12345678},        // R3 indirect
    '{1'b1,3'd0,1'b0,3'd0,2'd0,2'd1,32'h000000FF,32'h00000FFF}, // R6 disp8 -1
    '{1'b1,3'd0,1'b0,3'd0,2'd0,2'd1,32'hAAAA007F,32'h0000107F}, // R6 upper ignored
    '{1'b1,3'd0,1'b0,3'd0,2'd0,2'd2,32'h00008000,32'hFFFF9000}, // R6 disp16 sign
    '{1'b0,3'd0,1'b1,3'd1,2'd3,2'd3,32'h00000100,32'h00000180}, // R4 x8 + disp
    '{1'b1,3'd0,1'b1,3'd5,2'd2,2'd0,32'h0,32'h00001010},        // R4 x4 + base
    '{1'b1,3'd1,1'b0,3'd7,2'd3,2'd0,32'h0,32'h00000010},        // R5 index off
    '{1'b1,3'd7,1'b1,3'd1,2'd0,2'd0,32'h0,32'h0000000F},        // R7 carry out
    '{1'b1,3'd3,1'b1,3'd3,2'd1,2'd0,32'h0,32'h80000000},        // R4 R7 shifted out
    '{1'b1,3'd6,1'b0,3'd0,2'd0,2'd1,32'h00000001,32'h80000000}, // R7 wrap into sign
    '{1'b1,3'd2,1'b1,3'd2,2'd0,2'd2,32'h00000010,32'hFFFFFFF0}, // R3 R4 all terms
    '{1'b0,3'd4,1'b1,3'd4,2'd0,2'd0,32'h0,32'h12345678}         // R3 base off
  };

  function automatic logic [31:0] model(vec_t v);
    logic [31:0] s, d;
    s = 0;
    if (v.ub) s = s + regs[v.bs];
    if (v.ui) s = s + regs[v.is] * (32'd1 << v.sc);
    case (v.ds)
      2'd1: d = $signed(v.disp[7:0]);
      2'd2: d = $signed(v.disp[15:0]);
      2'd3: d = v.disp;
      default: d = 0;
    endcase
    return s + d;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    in_valid = 1'b1; use_base = v.ub; base_sel = v.bs; use_index = v.ui;
    index_sel = v.is; scale_code = v.sc; disp_size = v.ds; disp_bytes = v.disp;
  endtask

  initial begin
    #200000000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(ea_valid == 1'b0 && ea_out == 32'h0, "R1 reset", {ea_out[30:0], ea_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      #1;
      check(rf_base_addr == VECS[i].bs && rf_index_addr == VECS[i].is, "R3 R4 read addresses",
            {26'd0, rf_base_addr, rf_index_addr}, {26'd0, VECS[i].bs, VECS[i].is});
      @(negedge clk);
      check(ea_valid == 1'b1, "R2 valid after one clock", {31'd0, ea_valid}, 32'd1);
      check(ea_out == VECS[i].exp, $sformatf("R3-R7 vector %0d", i), ea_out, VECS[i].exp);
    end

    // R8 and R2: hold with in_valid low, even when inputs change
    in_valid = 1'b0; use_base = 1'b1; base_sel = 3'd7; disp_size = 2'd3; disp_bytes = 32'h55555555;
    @(negedge clk);
    check(ea_valid == 1'b0, "R2 valid drops", {31'd0, ea_valid}, 32'd0);
    check(ea_out == VECS[NV-1].exp, "R8 hold", ea_out, VECS[NV-1].exp);
    @(negedge clk);
    check(ea_out == VECS[NV-1].exp, "R8 hold second cycle", ea_out, VECS[NV-1].exp);

    // random descriptors against the model (R3 R4 R5 R6 R7)
    for (int k = 0; k < 300; k++) begin
      vec_t v;
      v = vec_t'({$urandom, $urandom, $urandom});
      drive(v);
      @(negedge clk);
      check(ea_out == model(v) && ea_valid, $sformatf("R7 random %0d", k), ea_out, model(v));
    end

    // R1 asynchronous reset mid-run
    in_valid = 1'b0;
    #3 rst_n = 1'b0;
    #2;
    check(ea_valid == 1'b0 && ea_out == 32'h0, "R1 async reset", ea_out, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(ea_valid == 1'b0, "R2 idle after reset", {31'd0, ea_valid}, 32'd0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule